// File: doc/BRIEF.md
# Serial Successive-Approximation Converter Control

This block is the digital control section of a 12-bit serial converter of the successive-approximation type. A rising edge on the convert line takes a sample of the input and starts a conversion. Each rising edge of the externally supplied serial clock then resolves one more bit of the approximation register. On the same edge, the data pin moves to the next bit of the word being shifted out.

The analog comparator is replaced by a digital comparison against a test code at the `ain_code_i` port. The word shifted out during a conversion is always the result of the conversion before it.

Bursts of convert pulses sent while the serial clock is held still are decoded as power-down requests:

- Two such pulses select nap.
- Four such pulses select sleep.

A rising serial clock edge brings the block back to normal operation. A range-select input chooses straight binary coding or two's-complement coding for the result.

Top module: `sar_adc_ctrl`

## Requirements
- R1: After reset, `dout_oe_o`, `dout_o`, `nap_o` and `sleep_o` are all low.
- R2: A rising edge of `conv_i` that comes while the block is awake and not converting makes `dout_oe_o` high in the next cycle. At that point `dout_o` carries the most significant bit of the stored result.
- R3: Each rising edge of `sck_i` during a conversion does two things: it resolves one approximation bit, and it moves `dout_o` to the next lower bit, so the word leaves MSB first. After the twelfth rising edge, `dout_oe_o` goes low in the next cycle.
- R4: The word shifted out is the result of the previous completed conversion. The first word after reset is all zeros.
- R5: `range_bipolar_i` is sampled at the start of a conversion.
  - When it is low, the result equals the input code (straight binary).
  - When it is high, the result is the input code with its MSB inverted (two's complement).
- R6: A rising edge of `conv_i` during a conversion does not restart the conversion and does not take a new sample.
- R7: Two rising edges of `conv_i` with no `sck_i` edge between them select nap. `nap_o` rises in the cycle after `conv_i` falls after the second pulse. Any conversion in progress is abandoned and `dout_oe_o` goes low.
- R8: Four such pulses select sleep. `sleep_o` rises after the fall of the fourth pulse and `nap_o` drops at the same time. `nap_o` and `sleep_o` are never high together.
- R9: A rising edge of `sck_i` during nap or sleep clears both `nap_o` and `sleep_o` in the next cycle.
- R10: Any edge of `sck_i`, rising or falling, clears the convert pulse count.
- R11: In nap or sleep, a rising edge of `conv_i` starts no conversion and `dout_oe_o` stays low.
- R12: An abandoned conversion leaves the stored result unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples conv_i and sck_i |
| rst_n | input | 1 | Asynchronous active-low reset |
| conv_i | input | 1 | Convert request; its rising edge samples and starts |
| sck_i | input | 1 | Serial clock; its rising edge steps the conversion and the output |
| range_bipolar_i | input | 1 | 0 selects straight binary, 1 selects two's complement |
| ain_code_i | input | 12 | Digital stand-in for the analog input level |
| dout_o | output | 1 | Serial result bit; low when not driven |
| dout_oe_o | output | 1 | High while dout_o should drive the pin |
| nap_o | output | 1 | High in nap |
| sleep_o | output | 1 | High in sleep |

## Verification
A stale or corrupted stored result never shows during the conversion that produces it. It appears only one conversion later, as a wrong word on `dout_o`. For that reason the bench chains conversions with distinct codes and checks every word against the previous sample.

A wrong pulse count or a wrong power state shows on `nap_o` or `sleep_o` in the cycle after `conv_i` falls, or after a serial clock edge. A wrong bit index shows as an early or late fall of `dout_oe_o` relative to the twelfth serial clock rise. The bench compares all four outputs with its reference model on every clock.

// File: rtl/sar_adc_pkg.sv
package sar_adc_pkg;

    typedef enum logic [1:0] {
        PWR_AWAKE = 2'd0,
        PWR_NAP   = 2'd1,
        PWR_SLEEP = 2'd2
    } pwr_e;

    localparam int unsigned DEF_WIDTH        = 12;
    localparam int unsigned DEF_NAP_PULSES   = 2;
    localparam int unsigned DEF_SLEEP_PULSES = 4;

endpackage

// File: rtl/sar_edge_det.sv
module sar_edge_det (
    input  logic clk,
    input  logic rst_n,
    input  logic conv_i,
    input  logic sck_i,
    output logic conv_rise_o,
    output logic conv_fall_o,
    output logic sck_rise_o,
    output logic sck_edge_o
);

    typedef struct packed {
        logic conv;
        logic sck;
    } prev_t;

    prev_t prev_d, prev_q;

    always_comb begin
        prev_d.conv = conv_i;
        prev_d.sck  = sck_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= '0;
        end else begin
            prev_q <= prev_d;
        end
    end

    assign conv_rise_o = conv_i & ~prev_q.conv;
    assign conv_fall_o = ~conv_i & prev_q.conv;
    assign sck_rise_o  = sck_i & ~prev_q.sck;
    assign sck_edge_o  = sck_i ^ prev_q.sck;

endmodule

// File: rtl/sar_pwr_ctl.sv
module sar_pwr_ctl #(
    parameter int unsigned NAP_PULSES   = sar_adc_pkg::DEF_NAP_PULSES,
    parameter int unsigned SLEEP_PULSES = sar_adc_pkg::DEF_SLEEP_PULSES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              conv_rise_i,
    input  logic              conv_fall_i,
    input  logic              sck_rise_i,
    input  logic              sck_edge_i,
    output sar_adc_pkg::pwr_e pwr_o,
    output logic              pd_enter_o
);
    import sar_adc_pkg::*;

    localparam int unsigned CW = $clog2(SLEEP_PULSES + 1);
    localparam logic [CW-1:0] NAP_LIM   = CW'(NAP_PULSES);
    localparam logic [CW-1:0] SLEEP_LIM = CW'(SLEEP_PULSES);

    typedef struct packed {
        pwr_e          pwr;
        logic [CW-1:0] cnt;
    } pstate_t;

    pstate_t st_d, st_q;
    logic    pd_enter_d;

    always_comb begin
        st_d       = st_q;
        pd_enter_d = 1'b0;

        // pulse counter: cleared by any serial clock edge, saturating
        if (sck_edge_i) begin
            st_d.cnt = '0;
        end
        if (conv_rise_i && (st_d.cnt < SLEEP_LIM)) begin
            st_d.cnt = st_d.cnt + CW'(1);
        end

        // power state: wake has priority over a request
        if (sck_rise_i && (st_q.pwr != PWR_AWAKE)) begin
            st_d.pwr = PWR_AWAKE;
        end else if (conv_fall_i && (st_q.cnt >= SLEEP_LIM)) begin
            st_d.pwr   = PWR_SLEEP;
            pd_enter_d = (st_q.pwr == PWR_AWAKE);
        end else if (conv_fall_i && (st_q.cnt >= NAP_LIM) && (st_q.pwr == PWR_AWAKE)) begin
            st_d.pwr   = PWR_NAP;
            pd_enter_d = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{pwr: PWR_AWAKE, cnt: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign pwr_o      = st_q.pwr;
    assign pd_enter_o = pd_enter_d;

endmodule

// File: rtl/sar_engine.sv
module sar_engine #(
    parameter int unsigned WIDTH = sar_adc_pkg::DEF_WIDTH
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             abort_i,
    input  logic             step_i,
    input  logic [WIDTH-1:0] ain_i,
    input  logic             bipolar_i,
    output logic             busy_o,
    output logic             dout_o
);

    localparam int unsigned IW = $clog2(WIDTH);
    localparam logic [IW-1:0] TOP_IDX = IW'(WIDTH - 1);

    typedef struct packed {
        logic             busy;
        logic [IW-1:0]    idx;
        logic [WIDTH-1:0] sar;
        logic [WIDTH-1:0] samp;
        logic             bip;
        logic [WIDTH-1:0] res;
        logic [WIDTH-1:0] shf;
    } eng_t;

    eng_t e_d, e_q;
    logic [WIDTH-1:0] trial;
    logic [WIDTH-1:0] sar_next;

    always_comb begin
        e_d      = e_q;
        trial    = e_q.sar;
        trial[e_q.idx] = 1'b1;
        sar_next = (trial <= e_q.samp) ? trial : e_q.sar;

        if (abort_i) begin
            e_d.busy = 1'b0;
        end else if (start_i && !e_q.busy) begin
            e_d.busy = 1'b1;
            e_d.idx  = TOP_IDX;
            e_d.sar  = '0;
            e_d.samp = ain_i;
            e_d.bip  = bipolar_i;
            e_d.shf  = e_q.res;
        end else if (e_q.busy && step_i) begin
            e_d.sar = sar_next;
            e_d.shf = {e_q.shf[WIDTH-2:0], 1'b0};
            if (e_q.idx == '0) begin
                e_d.busy = 1'b0;
                e_d.res  = sar_next;
                if (e_q.bip) begin
                    e_d.res[WIDTH-1] = ~sar_next[WIDTH-1];
                end
            end else begin
                e_d.idx = e_q.idx - IW'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            e_q <= '0;
        end else begin
            e_q <= e_d;
        end
    end

    assign busy_o = e_q.busy;
    assign dout_o = e_q.busy & e_q.shf[WIDTH-1];

endmodule

// File: rtl/sar_adc_ctrl.sv
module sar_adc_ctrl #(
    parameter int unsigned WIDTH        = sar_adc_pkg::DEF_WIDTH,
    parameter int unsigned NAP_PULSES   = sar_adc_pkg::DEF_NAP_PULSES,
    parameter int unsigned SLEEP_PULSES = sar_adc_pkg::DEF_SLEEP_PULSES
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             conv_i,
    input  logic             sck_i,
    input  logic             range_bipolar_i,
    input  logic [WIDTH-1:0] ain_code_i,
    output logic             dout_o,
    output logic             dout_oe_o,
    output logic             nap_o,
    output logic             sleep_o
);
    import sar_adc_pkg::*;

    logic conv_rise, conv_fall, sck_rise, sck_edge;
    logic pd_enter, start;
    pwr_e pwr;

    sar_edge_det i_edge (
        .clk        (clk),
        .rst_n      (rst_n),
        .conv_i     (conv_i),
        .sck_i      (sck_i),
        .conv_rise_o(conv_rise),
        .conv_fall_o(conv_fall),
        .sck_rise_o (sck_rise),
        .sck_edge_o (sck_edge)
    );

    sar_pwr_ctl #(
        .NAP_PULSES  (NAP_PULSES),
        .SLEEP_PULSES(SLEEP_PULSES)
    ) i_pwr (
        .clk        (clk),
        .rst_n      (rst_n),
        .conv_rise_i(conv_rise),
        .conv_fall_i(conv_fall),
        .sck_rise_i (sck_rise),
        .sck_edge_i (sck_edge),
        .pwr_o      (pwr),
        .pd_enter_o (pd_enter)
    );

    assign start = conv_rise & (pwr == PWR_AWAKE);

    sar_engine #(
        .WIDTH(WIDTH)
    ) i_eng (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (start),
        .abort_i  (pd_enter),
        .step_i   (sck_rise),
        .ain_i    (ain_code_i),
        .bipolar_i(range_bipolar_i),
        .busy_o   (dout_oe_o),
        .dout_o   (dout_o)
    );

    assign nap_o   = (pwr == PWR_NAP);
    assign sleep_o = (pwr == PWR_SLEEP);

endmodule

// File: rtl/sar_adc_ctrl_chk.sv
module sar_adc_ctrl_chk (
    input logic clk,
    input logic rst_n,
    input logic conv_i,
    input logic sck_i,
    input logic dout_o,
    input logic dout_oe_o,
    input logic nap_o,
    input logic sleep_o
);

    logic conv_p, sck_p;
    logic conv_up, sck_up;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            conv_p <= 1'b0;
            sck_p  <= 1'b0;
        end else begin
            conv_p <= conv_i;
            sck_p  <= sck_i;
        end
    end

    assign conv_up = conv_i & ~conv_p;
    assign sck_up  = sck_i & ~sck_p;

    AST_OE_NEEDS_START: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dout_oe_o) |-> $past(conv_up)); // R2

    AST_DOUT_HOLDS_BETWEEN_CLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (dout_oe_o && $past(dout_oe_o) && !$past(sck_up)) |-> $stable(dout_o)); // R3

    AST_SINGLE_POWER_STATE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({nap_o, sleep_o})); // R8

    AST_WAKE_ON_SCK: assert property (@(posedge clk) disable iff (!rst_n)
        ((nap_o || sleep_o) && sck_up) |=> (!nap_o && !sleep_o)); // R9

    AST_NO_DRIVE_ASLEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (nap_o || sleep_o) |-> !dout_oe_o); // R11

endmodule

bind sar_adc_ctrl sar_adc_ctrl_chk i_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .conv_i   (conv_i),
    .sck_i    (sck_i),
    .dout_o   (dout_o),
    .dout_oe_o(dout_oe_o),
    .nap_o    (nap_o),
    .sleep_o  (sleep_o)
);

// File: tb/test_sar_adc_ctrl.sv
module test_sar_adc_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam int WDOG_CYCLES = 20000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic conv = 1'b0;
    logic sck = 1'b0;
    logic bip = 1'b0;
    logic [11:0] ain = '0;
    logic dout, oe, nap, sleep;

    int nvec = 0;
    int nfail = 0;
    int cyc = 0;
    bit done = 1'b0;
    string cur = "R1";

    always #(CLK_PERIOD/2) clk = ~clk;

    sar_adc_ctrl i_sar_adc_ctrl (
        .clk            (clk),
        .rst_n          (rst_n),
        .conv_i         (conv),
        .sck_i          (sck),
        .range_bipolar_i(bip),
        .ain_code_i     (ain),
        .dout_o         (dout),
        .dout_oe_o      (oe),
        .nap_o          (nap),
        .sleep_o        (sleep)
    );

    // ---------------- behavioural reference model ----------------
    bit [11:0] m_last, m_samp;
    bit        m_bip;
    bit        mq[$];
    int        m_cnt, m_pwr;
    bit        mcp, msp;
    bit        cr, cf, sr, se, busy_old, aborted;
    int        oc, op;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_last = '0; mq.delete(); m_cnt = 0; m_pwr = 0; mcp = 0; msp = 0;
        end else begin
            cr = conv && !mcp; cf = !conv && mcp;
            sr = sck && !msp;  se = (sck != msp);
            oc = m_cnt; op = m_pwr;
            busy_old = (mq.size() > 0);
            aborted = 1'b0;
            if (sr && op != 0) m_pwr = 0;
            else if (cf && oc >= 4) begin
                m_pwr = 2;
                if (op == 0) begin aborted = 1'b1; mq.delete(); end
            end else if (cf && oc >= 2 && op == 0) begin
                m_pwr = 1; aborted = 1'b1; mq.delete();
            end
            m_cnt = se ? 0 : oc;
            if (cr && m_cnt < 4) m_cnt++;
            if (!aborted) begin
                if (cr && op == 0 && !busy_old) begin
                    m_samp = ain; m_bip = bip;
                    for (int i = 11; i >= 0; i--) mq.push_back(m_last[i]);
                end else if (busy_old && sr) begin
                    void'(mq.pop_front());
                    if (mq.size() == 0) m_last = m_bip ? (m_samp ^ 12'h800) : m_samp;
                end
            end
            mcp = conv; msp = sck;
        end
    end

    always @(negedge clk) begin
        if (rst_n && !done) begin
            logic [3:0] expv, actv;
            expv = {mq.size() > 0, (mq.size() > 0) ? mq[0] : 1'b0, m_pwr == 1, m_pwr == 2};
            actv = {oe, dout, nap, sleep};
            nvec++;
            if (actv !== expv) begin
                nfail++;
                $display("FAIL %s cycle %0d: actual {oe,dout,nap,sleep}=%b expected %b", cur, cyc, actv, expv);
            end
        end
    end

    // ---------------- watchdog ----------------
    always @(posedge clk) begin
        cyc++;
        if (cyc > WDOG_CYCLES && !done) begin
            done = 1'b1;
            nfail++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
            $finish;
        end
    end

    // ---------------- helpers ----------------
    logic [11:0] rw;
    int rpos;

    task automatic chk(input string req, input int act, input int exp);
        nvec++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic conv_pulse();
        @(negedge clk) conv = 1'b1;
        @(negedge clk) conv = 1'b0;
        @(negedge clk);
        rpos = 11;
    endtask

    task automatic shift_n(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            rw[rpos] = dout;
            rpos--;
            sck = 1'b1;
            @(negedge clk) sck = 1'b0;
        end
        @(negedge clk);
    endtask

    task automatic sck_pulse();
        @(negedge clk) sck = 1'b1;
        @(negedge clk) sck = 1'b0;
        @(negedge clk);
    endtask

    // ---------------- stimulus ----------------
    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        chk("R1 oe", oe, 0); chk("R1 dout", dout, 0);
        chk("R1 nap", nap, 0); chk("R1 sleep", sleep, 0);

        cur = "R2"; ain = 12'h5A3; bip = 1'b0;
        conv_pulse();
        chk("R2 oe after convert", oe, 1);
        cur = "R3"; shift_n(12);
        chk("R4 first word zero", rw, 12'h000);
        chk("R3 oe low after 12 clocks", oe, 0);

        cur = "R4"; ain = 12'h123; bip = 1'b1;
        conv_pulse(); shift_n(12);
        chk("R4 unipolar previous word", rw, 12'h5A3);

        cur = "R5"; ain = 12'h0FF; bip = 1'b0;
        conv_pulse(); shift_n(12);
        chk("R5 bipolar coding", rw, 12'h923);

        ain = 12'hC01; bip = 1'b1;
        conv_pulse(); shift_n(12);
        chk("R5 straight coding", rw, 12'h0FF);

        cur = "R6"; ain = 12'h7FE; bip = 1'b0;
        conv_pulse(); shift_n(5);
        ain = 12'hFFF;
        conv_pulse(); rpos = 6;
        chk("R6 oe kept", oe, 1); chk("R6 no nap", nap, 0);
        shift_n(7);
        chk("R6 word continues", rw, 12'h401);
        ain = 12'h333;
        conv_pulse(); shift_n(12);
        chk("R6 sample not retaken", rw, 12'h7FE);

        cur = "R7"; ain = 12'hABC;
        conv_pulse(); conv_pulse();
        chk("R7 nap", nap, 1); chk("R7 oe dropped", oe, 0);
        cur = "R11"; conv_pulse();
        chk("R11 no start in nap", oe, 0); chk("R11 still nap", nap, 1);
        cur = "R9"; sck_pulse();
        chk("R9 wake from nap", nap, 0);

        cur = "R12"; ain = 12'h111;
        conv_pulse(); shift_n(12);
        chk("R12 aborted not stored", rw, 12'h333);

        cur = "R8";
        conv_pulse(); conv_pulse();
        chk("R7 nap after two", nap, 1);
        conv_pulse(); conv_pulse();
        chk("R8 sleep after four", sleep, 1); chk("R8 nap cleared", nap, 0);
        cur = "R9"; sck_pulse();
        chk("R9 wake from sleep", sleep, 0);

        cur = "R10";
        conv_pulse(); shift_n(1);
        conv_pulse(); rpos = 10;
        chk("R10 count cleared no nap", nap, 0); chk("R10 oe kept", oe, 1);
        shift_n(11);
        chk("R10 word", rw, 12'h111);

        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end

endmodule